// File: doc/BRIEF.md
# Phase-Shifted Three-Level Bridge Gate Generator

This block produces the gate commands for a soft-switched, three-level full-bridge DC-DC stage built from eight switches. Diagonal switches share one command, so the block drives four pair outputs. The forward outer pair (S1/S8) and the reverse outer pair (S4/S5) form the leading leg. The forward inner pair (S2/S7) and the reverse inner pair (S3/S6) form the lagging leg. A free-running counter fixes the switching period. Every pair conducts for half a period, shortened by the dead band at its own turn-on.

The duty command does not set a pulse width. It sets how far the leading leg is shifted ahead of the lagging leg. Power reaches the transformer only while a forward or a reverse diagonal is fully on. The phase delay is the duty fraction times the half period. It is clamped so that two dead bands still fit in every half cycle. Period, duty and dead-time inputs are sampled only at a period boundary, so the outputs never change shape partway through a cycle. A one-clock marker flags the start of each half cycle.

Top module: `bridge_phase_pwm`

## Requirements
- R1: While the reset input is low, all five outputs are low at once. With the enable low, all five outputs are low one clock later, whatever the configuration inputs do.
- R2: The period P in clocks is the period input with bit 0 cleared, and never less than 4. The half period is H = P/2. The edge that first samples the enable high loads the configuration and starts at position 0. Position k of a period is shown on the outputs after the next clock edge.
- R3: The dead time DT is the dead input, with 0 treated as 1. The forward inner output is high at positions DT to H-1. The reverse inner output is high at positions H+DT to P-1.
- R4: The phase delay PH is floor(duty*H/256), with duty an 8-bit unsigned fraction. It is limited to H-2*DT, or to 0 when 2*DT is not below H.
- R5: The reverse outer output is high at positions PH+DT to H+PH-1. The forward outer output is high at positions H+PH+DT to P-1 and at positions 0 to PH-1.
- R6: In the first period after enable, the forward outer output stays low at positions 0 to PH-1. It therefore enters its dead band like every other output.
- R7: The two outputs of one leg are never high together. An output never rises on the clock after its leg partner was high.
- R8: Configuration inputs take effect only at the start of a period. A change made partway through a period leaves the rest of that period unchanged.
- R9: The half-cycle marker is high for exactly one clock, at positions 0 and H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable |
| period_i | input | CNT_W | Switching period in clocks |
| duty_i | input | DUTY_W | Duty fraction, full scale 2^DUTY_W |
| dead_i | input | DT_W | Dead band in clocks |
| gate_fwd_outer_o | output | 1 | Forward outer pair S1/S8 |
| gate_fwd_inner_o | output | 1 | Forward inner pair S2/S7 |
| gate_rev_inner_o | output | 1 | Reverse inner pair S3/S6 |
| gate_rev_outer_o | output | 1 | Reverse outer pair S4/S5 |
| half_mark_o | output | 1 | Half-cycle marker |

## Verification
The edge that first samples the enable high still leaves every output low. The decoded value of position k appears after edge k+1 from that point, and the marker follows the same rule. A configuration change shows in the position-0 pattern of the following period. A low enable clears the outputs one edge after it is sampled, while reset clears them at once. The bench drives its inputs and reads the outputs 1 ns after each rising edge, so every check falls on a settled value with a known position.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

  localparam int NUM_LEGS  = 2;
  localparam int LEG_INNER = 0;
  localparam int LEG_OUTER = 1;

  typedef struct packed {
    logic fwd_outer;
    logic fwd_inner;
    logic rev_inner;
    logic rev_outer;
  } gate_set_t;

endpackage

// File: rtl/bpp_cfg_latch.sv
module bpp_cfg_latch #(
  parameter int CNT_W  = 16,
  parameter int DUTY_W = 8,
  parameter int DT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DT_W-1:0]   dead_i,
  output logic [CNT_W-1:0]  per_o,
  output logic [CNT_W-1:0]  half_o,
  output logic [CNT_W-1:0]  phase_o,
  output logic [CNT_W-1:0]  dead_o
);

  localparam int PW = CNT_W + DUTY_W;

  logic [CNT_W-1:0] per_even, per_eff, half_eff, dt_eff, lim, ph_eff;
  logic [CNT_W:0]   two_dt;
  logic [PW-1:0]    prod, ph_raw;

  always_comb begin
    per_even = period_i & ~CNT_W'(1);
    per_eff  = (per_even < CNT_W'(4)) ? CNT_W'(4) : per_even;
    half_eff = per_eff >> 1;
    dt_eff   = (dead_i == '0) ? CNT_W'(1) : CNT_W'(dead_i);
    two_dt   = {dt_eff, 1'b0};
    lim      = (two_dt >= {1'b0, half_eff}) ? '0 : CNT_W'({1'b0, half_eff} - two_dt);
    prod     = PW'(duty_i) * PW'(half_eff);
    ph_raw   = prod >> DUTY_W;
    ph_eff   = (ph_raw > PW'(lim)) ? lim : CNT_W'(ph_raw);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_o   <= '0;
      half_o  <= '0;
      phase_o <= '0;
      dead_o  <= '0;
    end else if (load_i) begin
      per_o   <= per_eff;
      half_o  <= half_eff;
      phase_o <= ph_eff;
      dead_o  <= dt_eff;
    end
  end

endmodule

// File: rtl/bpp_period_cnt.sv
module bpp_period_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] per_i,
  output logic             run_o,
  output logic             first_o,
  output logic             load_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic             run_q, run_d, first_q, first_d, wrap;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign wrap   = run_q && (cnt_q == per_i - CNT_W'(1));
  assign load_o = en_i && (!run_q || wrap);

  always_comb begin
    run_d   = run_q;
    first_d = first_q;
    cnt_d   = cnt_q;
    if (!en_i) begin
      run_d   = 1'b0;
      first_d = 1'b0;
      cnt_d   = '0;
    end else if (!run_q) begin
      run_d   = 1'b1;
      first_d = 1'b1;
      cnt_d   = '0;
    end else if (wrap) begin
      first_d = 1'b0;
      cnt_d   = '0;
    end else begin
      cnt_d   = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      first_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      run_q   <= run_d;
      first_q <= first_d;
      cnt_q   <= cnt_d;
    end
  end

  assign run_o   = run_q;
  assign first_o = first_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/bpp_leg_decode.sv
module bpp_leg_decode #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] shift_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic             first_i,
  output logic             lead_o,
  output logic             trail_o
);

  logic           wrapped;
  logic [CNT_W:0] rel, trail_start;

  always_comb begin
    wrapped     = cnt_i < shift_i;
    rel         = wrapped ? ({1'b0, cnt_i} + {1'b0, per_i} - {1'b0, shift_i})
                          : ({1'b0, cnt_i} - {1'b0, shift_i});
    trail_start = {1'b0, half_i} + {1'b0, dead_i};
    lead_o      = (rel >= {1'b0, dead_i}) && (rel < {1'b0, half_i});
    trail_o     = (rel >= trail_start) && !(wrapped && first_i);
  end

endmodule

// File: rtl/bridge_phase_pwm.sv
module bridge_phase_pwm
  import bpp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DUTY_W = 8,
  parameter int DT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DT_W-1:0]   dead_i,
  output logic              gate_fwd_outer_o,
  output logic              gate_fwd_inner_o,
  output logic              gate_rev_inner_o,
  output logic              gate_rev_outer_o,
  output logic              half_mark_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             run, first, load;
  logic [CNT_W-1:0] cnt, per_q, half_q, phase_q, dead_q;
  logic [NUM_LEGS-1:0] lead, trail;
  gate_set_t        gate_d, gate_q;
  logic             mark_d, mark_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  bpp_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .en_i   (en_i),
    .per_i  (per_q),
    .run_o  (run),
    .first_o(first),
    .load_o (load),
    .cnt_o  (cnt)
  );

  bpp_cfg_latch #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .DT_W(DT_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .load_i  (load),
    .period_i(period_i),
    .duty_i  (duty_i),
    .dead_i  (dead_i),
    .per_o   (per_q),
    .half_o  (half_q),
    .phase_o (phase_q),
    .dead_o  (dead_q)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    logic [CNT_W-1:0] shift;
    if (g == LEG_OUTER) begin : g_shifted
      assign shift = phase_q;
    end else begin : g_aligned
      assign shift = '0;
    end
    bpp_leg_decode #(.CNT_W(CNT_W)) u_dec (
      .cnt_i  (cnt),
      .shift_i(shift),
      .per_i  (per_q),
      .half_i (half_q),
      .dead_i (dead_q),
      .first_i(first),
      .lead_o (lead[g]),
      .trail_o(trail[g])
    );
  end

  always_comb begin
    gate_d = '0;
    mark_d = 1'b0;
    if (run && en_i) begin
      gate_d.fwd_inner = lead[LEG_INNER];
      gate_d.rev_inner = trail[LEG_INNER];
      gate_d.rev_outer = lead[LEG_OUTER];
      gate_d.fwd_outer = trail[LEG_OUTER];
      mark_d           = (cnt == '0) || (cnt == half_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      mark_q <= 1'b0;
    end else if (!rst_n_int) begin
      gate_q <= '0;
      mark_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
      mark_q <= mark_d;
    end
  end

  assign gate_fwd_outer_o = gate_q.fwd_outer;
  assign gate_fwd_inner_o = gate_q.fwd_inner;
  assign gate_rev_inner_o = gate_q.rev_inner;
  assign gate_rev_outer_o = gate_q.rev_outer;
  assign half_mark_o      = mark_q;

endmodule

// File: rtl/bpp_gate_chk.sv
module bpp_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic fo,
  input logic fi,
  input logic ri,
  input logic ro,
  input logic mk
);

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !(fo || fi || ri || ro || mk)); // R1

  AST_OUTER_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fo && ro)); // R7

  AST_INNER_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fi && ri)); // R7

  AST_OUTER_REV_DEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ro) |-> !$past(fo)); // R7

  AST_OUTER_FWD_DEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fo) |-> !$past(ro)); // R7

  AST_INNER_REV_DEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ri) |-> !$past(fi)); // R7

  AST_INNER_FWD_DEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fi) |-> !$past(ri)); // R7

  AST_MARK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mk |=> !mk); // R9

endmodule

bind bridge_phase_pwm bpp_gate_chk u_gate_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .fo    (gate_fwd_outer_o),
  .fi    (gate_fwd_inner_o),
  .ri    (gate_rev_inner_o),
  .ro    (gate_rev_outer_o),
  .mk    (half_mark_o)
);

// File: tb/bridge_phase_pwm_tb_top.sv
`timescale 1ns/1ps
module bridge_phase_pwm_tb_top;

  localparam int CNT_W  = 16;
  localparam int DUTY_W = 8;
  localparam int DT_W   = 8;
  localparam int NV     = 7;

  // stimulus: period, duty, dead; expected: period, phase, dead
  localparam int T_PER [NV] = '{20, 40, 20, 16, 21, 24, 2};
  localparam int T_DUTY[NV] = '{128, 64, 255, 0, 128, 200, 128};
  localparam int T_DEAD[NV] = '{2, 3, 2, 1, 0, 7, 1};
  localparam int E_P   [NV] = '{20, 40, 20, 16, 20, 24, 4};
  localparam int E_PH  [NV] = '{5, 5, 6, 0, 5, 0, 0};
  localparam int E_DT  [NV] = '{2, 3, 2, 1, 1, 7, 1};

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              en_i;
  logic [CNT_W-1:0]  period_i;
  logic [DUTY_W-1:0] duty_i;
  logic [DT_W-1:0]   dead_i;
  logic fo, fi, ri, ro, mk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  bridge_phase_pwm #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .DT_W(DT_W)) dut_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .en_i            (en_i),
    .period_i        (period_i),
    .duty_i          (duty_i),
    .dead_i          (dead_i),
    .gate_fwd_outer_o(fo),
    .gate_fwd_inner_o(fi),
    .gate_rev_inner_o(ri),
    .gate_rev_outer_o(ro),
    .half_mark_o     (mk)
  );

  function automatic logic [4:0] model(int k, int p, int ph, int dt, bit first);
    int h = p / 2;
    logic a, b, c, d, m;
    a = (k >= h + ph + dt) || ((k < ph) && !first);
    b = (k >= dt) && (k < h);
    c = (k >= h + dt);
    d = (k >= ph + dt) && (k < h + ph);
    m = (k == 0) || (k == h);
    return {a, b, c, d, m};
  endfunction

  task automatic chk(input logic [4:0] exp, input string req);
    logic [4:0] act = {fo, fi, ri, ro, mk};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic step(int k, int p, int ph, int dt, bit first, string req);
    tick();
    chk(model(k, p, ph, dt, first), req);
  endtask

  task automatic set_cfg(int v);
    period_i = CNT_W'(T_PER[v]);
    duty_i   = DUTY_W'(T_DUTY[v]);
    dead_i   = DT_W'(T_DEAD[v]);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    en_i   = 1'b0;
    period_i = '0;
    duty_i   = '0;
    dead_i   = '0;
    repeat (3) tick();
    chk(5'b0, "R1 reset state");
    rst_ni = 1'b1;
    repeat (4) tick();

    // table walk: two full periods per vector
    for (int v = 0; v < NV; v++) begin
      en_i = 1'b0;
      set_cfg(v);
      tick();
      chk(5'b0, "R1 idle before enable");
      en_i = 1'b1;
      tick();
      chk(5'b0, "R2 enabling edge still low");
      for (int n = 0; n < 2 * E_P[v]; n++)
        step(n % E_P[v], E_P[v], E_PH[v], E_DT[v], n < E_P[v],
             "R2 R3 R4 R5 R6 R9 pattern");
      en_i = 1'b0;
      tick();
      chk(5'b0, "R1 disable clears outputs");
    end

    // R8: mid-period change lands at the next period start
    set_cfg(0);
    tick();
    en_i = 1'b1;
    tick();
    chk(5'b0, "R8 enabling edge");
    for (int k = 0; k < 20; k++) begin
      step(k, 20, 5, 2, 1'b1, "R8 old config holds");
      if (k == 4) set_cfg(1);
    end
    for (int k = 0; k < 40; k++)
      step(k, 40, 5, 3, 1'b0, "R8 new config applied");

    // R1: configuration ignored while disabled
    en_i = 1'b0;
    tick();
    chk(5'b0, "R1 disabled");
    set_cfg(2);
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(5'b0, "R1 config change ignored while disabled");
    end

    // R1: reset mid-run clears at once
    set_cfg(0);
    en_i = 1'b1;
    tick();
    for (int k = 0; k < 8; k++)
      step(k, 20, 5, 2, 1'b1, "R5 before reset");
    rst_ni = 1'b0;
    #1;
    chk(5'b0, "R1 asynchronous reset");
    en_i = 1'b0;
    tick();
    rst_ni = 1'b1;
    repeat (4) tick();
    chk(5'b0, "R1 after reset release");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule